// File: doc/BRIEF.md
# Per-Thread Memory Slowdown Estimator

This block keeps a running estimate of how much each of N hardware threads is slowed down by sharing one memory system with the others. For every thread it counts the cycles in which the core cannot commit because a last-level cache miss is outstanding. That count is the thread's shared stall time. Each time the memory scheduler issues a request, the block adds an interference term. Threads left waiting on the same bus or bank are charged the service time of the issued command. The issuing thread itself is charged the extra latency it paid when its row would have been open had it run alone. Every charge is divided by the thread's count of outstanding requests, so that the extra stall is spread across accesses that overlap.

The stall time a thread would have seen running alone is taken as shared stall time minus interference. The slowdown is the ratio of shared stall time to that estimate, reported as a fixed-point number with four fraction bits. From the per-thread ratios the block registers the index of the worst-off thread. It also registers a flag that rises when the largest ratio divided by the smallest exceeds a programmable threshold. A fairness-aware arbiter reads both, one cycle after the counters that produced them.

Top module: `slowdown_est`

## Requirements
- R1: A thread's shared-stall counter rises by exactly one at each clock edge at which its stall bit is high (saturating at all ones) and holds otherwise.
- R2: Synchronous reset clears every counter, every interference term and every stored row. All outputs read zero during reset. One edge after reset each slowdown reads 16 (1.0), the worst index is 0 and the flag is low.
- R3: On a schedule event, every thread other than the scheduled one whose bus-ready or bank-ready bit is high has its interference raised by floor(service / max(outstanding, 1)).
- R4: Each thread keeps one stored row per bank, written with the event's row on every event of that thread. The scheduled thread's interference rises by floor(extra latency / max(outstanding, 1)) only when the stored row for that bank is valid and equal to the event's row; otherwise it does not change.
- R5: The slowdown of thread t is floor(max(S,1)·16 / max(S−I,1)), where S is shared stall and I is interference, giving 4 fraction bits. It is packed at bits [t·20 +: 20].
- R6: The worst-thread index names the thread with the largest exact ratio, and the lowest index wins among equal ratios.
- R7: The flag is high when the largest ratio divided by the smallest ratio is strictly greater than the threshold divided by 16.
- R8: The slowdowns, the worst index and the flag are registered: they reflect counters, interference and threshold as they stood at the previous clock edge.
- R9: With no schedule event, every interference term holds. A thread that is neither scheduled nor ready keeps its interference through an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | NTHR | Per-thread commit stall caused by a memory miss |
| sched_vld_i | input | 1 | A request was scheduled this cycle |
| sched_thr_i | input | TID_W | Thread of the scheduled request |
| sched_bank_i | input | BID_W | Bank of the scheduled request |
| sched_row_i | input | ROW_W | Row of the scheduled request |
| sched_svc_i | input | LAT_W | Cycles the command occupies bus and bank |
| sched_xlat_i | input | LAT_W | Latency of this access above a row hit |
| rdy_bus_i | input | NTHR | Thread has a ready request waiting for the bus |
| rdy_bank_i | input | NTHR | Thread has a ready request waiting for the same bank |
| outst_i | input | NTHR*MLP_W | Per-thread outstanding request counts, thread t at [t*MLP_W +: MLP_W] |
| thresh_i | input | THR_W | Unfairness threshold, 4 fraction bits |
| slowdown_o | output | NTHR*SD_W | Per-thread slowdown, 4 fraction bits |
| worst_thr_o | output | TID_W | Thread with the largest slowdown |
| unfair_o | output | 1 | Max/min slowdown ratio exceeds threshold |

## Verification
The checks assume that the schedule thread and bank inputs are in range whenever the valid bit is high. They also assume that counters stay well below saturation, so that a counter that keeps rising can be treated as never falling. The bench keeps inside these limits: it drives at most a few dozen stall cycles per thread between resets, uses thread and bank numbers below four, and keeps service and latency values small. Stimulus changes only just after the falling clock edge. Each scenario starts from a fresh reset, so the expected ratios follow from the stall counts and charges applied in that scenario alone.

// File: rtl/sdest_pkg.sv
package sdest_pkg;
  localparam int unsigned DEF_THREADS = 4;
  localparam int unsigned DEF_BANKS   = 4;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned DEF_LAT_W   = 8;
  localparam int unsigned DEF_MLP_W   = 4;
  localparam int unsigned DEF_ROW_W   = 8;
  localparam int unsigned DEF_FRAC    = 4;
  localparam int unsigned DEF_THR_W   = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sdest_stall_ctr.sv
module sdest_stall_ctr #(
  parameter int unsigned NTHR  = sdest_pkg::DEF_THREADS,
  parameter int unsigned CNT_W = sdest_pkg::DEF_CNT_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NTHR-1:0]                stall,
  output logic [NTHR-1:0][CNT_W-1:0]     shared
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        shared[t] <= '0;
      end else if (stall[t] && (shared[t] != CNT_MAX)) begin
        shared[t] <= shared[t] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdest_intf_track.sv
module sdest_intf_track #(
  parameter int unsigned NTHR  = sdest_pkg::DEF_THREADS,
  parameter int unsigned NBANK = sdest_pkg::DEF_BANKS,
  parameter int unsigned CNT_W = sdest_pkg::DEF_CNT_W,
  parameter int unsigned LAT_W = sdest_pkg::DEF_LAT_W,
  parameter int unsigned MLP_W = sdest_pkg::DEF_MLP_W,
  parameter int unsigned ROW_W = sdest_pkg::DEF_ROW_W,
  localparam int unsigned TID_W  = sdest_pkg::idx_width(NTHR),
  localparam int unsigned BID_W  = sdest_pkg::idx_width(NBANK),
  localparam int unsigned SLOTS  = NTHR * NBANK,
  localparam int unsigned SLOT_W = sdest_pkg::idx_width(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ev_vld,
  input  logic [TID_W-1:0]            ev_thr,
  input  logic [BID_W-1:0]            ev_bank,
  input  logic [ROW_W-1:0]            ev_row,
  input  logic [LAT_W-1:0]            ev_svc,
  input  logic [LAT_W-1:0]            ev_xlat,
  input  logic [NTHR-1:0]             rdy_bus,
  input  logic [NTHR-1:0]             rdy_bank,
  input  logic [NTHR-1:0][MLP_W-1:0]  outst,
  output logic [NTHR-1:0][CNT_W-1:0]  intf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Divide a charge by the parallelism of a thread; power-of-two counts use a shift.
  function automatic logic [CNT_W-1:0] mlp_scale(input logic [LAT_W-1:0] amt,
                                                 input logic [MLP_W-1:0] cnt);
    logic [MLP_W-1:0] d;
    logic [LAT_W-1:0] q;
    d = (cnt == '0) ? MLP_W'(1) : cnt;
    if ($onehot(d)) begin
      q = amt;
      for (int k = 0; k < MLP_W; k++) begin
        if (d[k]) q = amt >> k;
      end
    end else begin
      q = LAT_W'(32'(amt) / 32'(d));
    end
    return CNT_W'(q);
  endfunction

  // Row each thread would have left open in each bank had it run alone.
  logic [ROW_W-1:0]  shadow_row [SLOTS];
  logic [SLOTS-1:0]  shadow_vld;
  logic [SLOT_W-1:0] slot;
  logic              alone_hit;

  assign slot      = SLOT_W'(SLOT_W'(ev_thr) * SLOT_W'(NBANK) + SLOT_W'(ev_bank));
  assign alone_hit = shadow_vld[slot] && (shadow_row[slot] == ev_row);

  always_ff @(posedge clk) begin
    if (ev_vld) shadow_row[slot] <= ev_row;
  end

  always_ff @(posedge clk) begin
    if (rst)         shadow_vld <= '0;
    else if (ev_vld) shadow_vld[slot] <= 1'b1;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CNT_W-1:0] charge;
    logic [CNT_W:0]   sum;

    always_comb begin
      charge = '0;
      if (ev_vld) begin
        if (ev_thr == TID_W'(t)) begin
          if (alone_hit) charge = mlp_scale(ev_xlat, outst[t]);
        end else if (rdy_bus[t] || rdy_bank[t]) begin
          charge = mlp_scale(ev_svc, outst[t]);
        end
      end
    end

    assign sum = {1'b0, intf[t]} + {1'b0, charge};

    always_ff @(posedge clk) begin
      if (rst)                  intf[t] <= '0;
      else if (ev_vld)          intf[t] <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sdest_eval.sv
module sdest_eval #(
  parameter int unsigned NTHR  = sdest_pkg::DEF_THREADS,
  parameter int unsigned CNT_W = sdest_pkg::DEF_CNT_W,
  parameter int unsigned FRAC  = sdest_pkg::DEF_FRAC,
  parameter int unsigned THR_W = sdest_pkg::DEF_THR_W,
  localparam int unsigned TID_W = sdest_pkg::idx_width(NTHR),
  localparam int unsigned SD_W  = CNT_W + FRAC,
  localparam int unsigned PRD_W = 2 * CNT_W,
  localparam int unsigned FLG_W = 2 * CNT_W + FRAC + THR_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NTHR-1:0][CNT_W-1:0]  shared,
  input  logic [NTHR-1:0][CNT_W-1:0]  intf,
  input  logic [THR_W-1:0]            thresh,
  output logic [NTHR-1:0][SD_W-1:0]   sd_q,
  output logic [TID_W-1:0]            worst_q,
  output logic                        unfair_q
);
  logic [CNT_W-1:0] num [NTHR];
  logic [CNT_W-1:0] den [NTHR];
  logic [NTHR-1:0][SD_W-1:0] sd_d;
  logic [TID_W-1:0] hi, lo;
  logic [FLG_W-1:0] lhs, rhs;

  for (genvar t = 0; t < NTHR; t++) begin : g_ratio
    always_comb begin
      num[t] = (shared[t] == '0) ? CNT_W'(1) : shared[t];
      den[t] = (shared[t] > intf[t]) ? (shared[t] - intf[t]) : CNT_W'(1);
      sd_d[t] = SD_W'({num[t], {FRAC{1'b0}}} / SD_W'(den[t]));
    end
  end

  // num[a]/den[a] > num[b]/den[b], exact.
  function automatic logic ratio_gt(input logic [CNT_W-1:0] na, input logic [CNT_W-1:0] da,
                                    input logic [CNT_W-1:0] nb, input logic [CNT_W-1:0] db);
    return (PRD_W'(na) * PRD_W'(db)) > (PRD_W'(nb) * PRD_W'(da));
  endfunction

  always_comb begin
    hi = '0;
    lo = '0;
    for (int t = 1; t < NTHR; t++) begin
      if (ratio_gt(num[t], den[t], num[hi], den[hi])) hi = TID_W'(t);
      if (ratio_gt(num[lo], den[lo], num[t], den[t])) lo = TID_W'(t);
    end
    lhs = FLG_W'(FLG_W'(num[hi]) * FLG_W'(den[lo])) << FRAC;
    rhs = FLG_W'(thresh) * FLG_W'(den[hi]) * FLG_W'(num[lo]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q     <= '0;
      worst_q  <= '0;
      unfair_q <= 1'b0;
    end else begin
      sd_q     <= sd_d;
      worst_q  <= hi;
      unfair_q <= lhs > rhs;
    end
  end
endmodule

// File: rtl/slowdown_est.sv
module slowdown_est #(
  parameter int unsigned NTHR  = sdest_pkg::DEF_THREADS,
  parameter int unsigned NBANK = sdest_pkg::DEF_BANKS,
  parameter int unsigned CNT_W = sdest_pkg::DEF_CNT_W,
  parameter int unsigned LAT_W = sdest_pkg::DEF_LAT_W,
  parameter int unsigned MLP_W = sdest_pkg::DEF_MLP_W,
  parameter int unsigned ROW_W = sdest_pkg::DEF_ROW_W,
  parameter int unsigned FRAC  = sdest_pkg::DEF_FRAC,
  parameter int unsigned THR_W = sdest_pkg::DEF_THR_W,
  localparam int unsigned TID_W = sdest_pkg::idx_width(NTHR),
  localparam int unsigned BID_W = sdest_pkg::idx_width(NBANK),
  localparam int unsigned SD_W  = CNT_W + FRAC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NTHR-1:0]         stall_i,
  input  logic                    sched_vld_i,
  input  logic [TID_W-1:0]        sched_thr_i,
  input  logic [BID_W-1:0]        sched_bank_i,
  input  logic [ROW_W-1:0]        sched_row_i,
  input  logic [LAT_W-1:0]        sched_svc_i,
  input  logic [LAT_W-1:0]        sched_xlat_i,
  input  logic [NTHR-1:0]         rdy_bus_i,
  input  logic [NTHR-1:0]         rdy_bank_i,
  input  logic [NTHR*MLP_W-1:0]   outst_i,
  input  logic [THR_W-1:0]        thresh_i,
  output logic [NTHR*SD_W-1:0]    slowdown_o,
  output logic [TID_W-1:0]        worst_thr_o,
  output logic                    unfair_o
);
  logic [NTHR-1:0][CNT_W-1:0] shared_q;
  logic [NTHR-1:0][CNT_W-1:0] intf_q;
  logic [NTHR-1:0][MLP_W-1:0] outst;
  logic [NTHR-1:0][SD_W-1:0]  sd_q;

  assign outst      = outst_i;
  assign slowdown_o = sd_q;

  sdest_stall_ctr #(.NTHR(NTHR), .CNT_W(CNT_W)) u_stall (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall_i),
    .shared (shared_q)
  );

  sdest_intf_track #(
    .NTHR(NTHR), .NBANK(NBANK), .CNT_W(CNT_W), .LAT_W(LAT_W),
    .MLP_W(MLP_W), .ROW_W(ROW_W)
  ) u_intf (
    .clk      (clk),
    .rst      (rst),
    .ev_vld   (sched_vld_i),
    .ev_thr   (sched_thr_i),
    .ev_bank  (sched_bank_i),
    .ev_row   (sched_row_i),
    .ev_svc   (sched_svc_i),
    .ev_xlat  (sched_xlat_i),
    .rdy_bus  (rdy_bus_i),
    .rdy_bank (rdy_bank_i),
    .outst    (outst),
    .intf     (intf_q)
  );

  sdest_eval #(.NTHR(NTHR), .CNT_W(CNT_W), .FRAC(FRAC), .THR_W(THR_W)) u_eval (
    .clk      (clk),
    .rst      (rst),
    .shared   (shared_q),
    .intf     (intf_q),
    .thresh   (thresh_i),
    .sd_q     (sd_q),
    .worst_q  (worst_thr_o),
    .unfair_q (unfair_o)
  );
endmodule

// File: rtl/slowdown_est_chk.sv
module slowdown_est_chk #(
  parameter int unsigned NTHR  = sdest_pkg::DEF_THREADS,
  parameter int unsigned CNT_W = sdest_pkg::DEF_CNT_W,
  parameter int unsigned FRAC  = sdest_pkg::DEF_FRAC,
  parameter int unsigned TID_W = 2,
  parameter int unsigned SD_W  = CNT_W + FRAC
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NTHR-1:0]            stall_i,
  input logic                       sched_vld_i,
  input logic [NTHR-1:0][CNT_W-1:0] shared,
  input logic [NTHR-1:0][CNT_W-1:0] intf,
  input logic [NTHR*SD_W-1:0]       slowdown_o,
  input logic [TID_W-1:0]           worst_thr_o
);
  localparam logic [SD_W-1:0] ONE = SD_W'(1) << FRAC;
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (rst) !stall_i[t] |=> $stable(shared[t])) else $error("shared moved without stall"); // R1
    AST_SHARED_NO_DROP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> shared[t] >= $past(shared[t])) else $error("shared decreased"); // R1
    AST_INTF_IDLE: assert property (@(posedge clk) disable iff (rst) !sched_vld_i |=> $stable(intf[t])) else $error("interference moved without event"); // R9
    AST_SD_AT_LEAST_ONE: assert property (@(posedge clk) disable iff (rst) primed |-> slowdown_o[t*SD_W +: SD_W] >= ONE) else $error("slowdown below 1.0"); // R5
    AST_WORST_DOMINATES: assert property (@(posedge clk) disable iff (rst) primed |-> slowdown_o[worst_thr_o*SD_W +: SD_W] >= slowdown_o[t*SD_W +: SD_W]) else $error("worst thread not largest"); // R6
  end
endmodule

bind slowdown_est slowdown_est_chk #(
  .NTHR(NTHR), .CNT_W(CNT_W), .FRAC(FRAC), .TID_W(TID_W), .SD_W(SD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall_i     (stall_i),
  .sched_vld_i (sched_vld_i),
  .shared      (shared_q),
  .intf        (intf_q),
  .slowdown_o  (slowdown_o),
  .worst_thr_o (worst_thr_o)
);

// File: tb/slowdown_est_bench.sv
module slowdown_est_bench;
  localparam int NT = 4;
  localparam int SDW = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  stall = '0;
  logic        vld = 1'b0;
  logic [1:0]  thr = '0;
  logic [1:0]  bank = '0;
  logic [7:0]  row = '0;
  logic [7:0]  svc = '0;
  logic [7:0]  xlat = '0;
  logic [3:0]  rbus = '0;
  logic [3:0]  rbank = '0;
  logic [15:0] outst = 16'h1111;
  logic [7:0]  thresh = 8'd32;
  logic [NT*SDW-1:0] sd;
  logic [1:0]  worst;
  logic        unf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slowdown_est u_slowdown_est (
    .clk(clk), .rst(rst), .stall_i(stall), .sched_vld_i(vld), .sched_thr_i(thr),
    .sched_bank_i(bank), .sched_row_i(row), .sched_svc_i(svc), .sched_xlat_i(xlat),
    .rdy_bus_i(rbus), .rdy_bank_i(rbank), .outst_i(outst), .thresh_i(thresh),
    .slowdown_o(sd), .worst_thr_o(worst), .unfair_o(unf)
  );

  // st0,st1,st2,st3 stall cycles | service | ready mask | expected worst | expected flag
  localparam logic [46:0] VEC [6] = '{
    {8'd10, 8'd10, 8'd10, 8'd10, 8'd0,  4'b0000, 2'd0, 1'b0},
    {8'd10, 8'd20, 8'd10, 8'd10, 8'd10, 4'b0010, 2'd1, 1'b0},
    {8'd10, 8'd20, 8'd10, 8'd10, 8'd11, 4'b0010, 2'd1, 1'b1},
    {8'd8,  8'd8,  8'd30, 8'd8,  8'd20, 4'b1100, 2'd3, 1'b1},
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd5,  4'b1110, 2'd0, 1'b0},
    {8'd40, 8'd40, 8'd40, 8'd40, 8'd20, 4'b1110, 2'd1, 1'b0}
  };

  function automatic int model_sd(input int s, input int i);
    int n, d;
    n = (s < 1) ? 1 : s;
    d = (s - i < 1) ? 1 : s - i;
    return (n * 16) / d;
  endfunction

  function automatic int sd_of(input int t);
    return int'(sd[t*SDW +: SDW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stall = '0; vld = 1'b0; rbus = '0; rbank = '0;
    outst = 16'h1111; thresh = 8'd32;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_stall(input int s0, input int s1, input int s2, input int s3);
    int n;
    n = s0;
    if (s1 > n) n = s1;
    if (s2 > n) n = s2;
    if (s3 > n) n = s3;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      stall = {c < s3, c < s2, c < s1, c < s0};
    end
    @(negedge clk);
    stall = '0;
  endtask

  task automatic event_go(input int t, input int b, input int r, input int sv, input int xl,
                          input logic [3:0] mb, input logic [3:0] mk);
    @(negedge clk);
    vld = 1'b1; thr = 2'(t); bank = 2'(b); row = 8'(r); svc = 8'(sv); xlat = 8'(xl);
    rbus = mb; rbank = mk;
    @(negedge clk);
    vld = 1'b0; rbus = '0; rbank = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    repeat (2) @(negedge clk);
    chk("R2 reset sd0", sd_of(0), 0);
    chk("R2 reset worst", int'(worst), 0);
    chk("R2 reset flag", int'(unf), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int t = 0; t < NT; t++) chk("R2 idle slowdown", sd_of(t), 16);
    chk("R2 idle flag", int'(unf), 0);

    // Table: R1 R3 R5 R6 R7 R9
    for (int v = 0; v < 6; v++) begin
      logic [46:0] e;
      int st [4];
      int sv;
      logic [3:0] m;
      e = VEC[v];
      st[0] = int'(e[46:39]); st[1] = int'(e[38:31]);
      st[2] = int'(e[30:23]); st[3] = int'(e[22:15]);
      sv = int'(e[14:7]); m = e[6:3];
      do_reset();
      run_stall(st[0], st[1], st[2], st[3]);
      if (v % 2 == 0) event_go(0, 0, 5, sv, 0, m, 4'b0000);
      else            event_go(0, 0, 5, sv, 0, 4'b0000, m);
      for (int t = 0; t < NT; t++)
        chk("R1 R3 R5 R9 table slowdown", sd_of(t), model_sd(st[t], (t != 0 && m[t]) ? sv : 0));
      chk("R6 table worst", int'(worst), int'(e[2:1]));
      chk("R7 table flag", int'(unf), int'(e[0]));
    end

    // R3: parallelism scaling (shift, divide, zero count)
    do_reset();
    outst = 16'h1141;
    run_stall(0, 20, 0, 0);
    event_go(0, 0, 1, 20, 0, 4'b0010, 4'b0000);
    chk("R3 mlp 4", sd_of(1), model_sd(20, 5));
    do_reset();
    outst = 16'h1131;
    run_stall(0, 20, 0, 0);
    event_go(0, 0, 1, 20, 0, 4'b0000, 4'b0010);
    chk("R3 mlp 3", sd_of(1), model_sd(20, 6));
    do_reset();
    outst = 16'h1101;
    run_stall(0, 20, 0, 0);
    event_go(0, 0, 1, 20, 0, 4'b0010, 4'b0000);
    chk("R3 R5 mlp 0 clamp", sd_of(1), 320);

    // R4: own-thread charge through stored rows
    do_reset();
    run_stall(18, 0, 0, 0);
    event_go(0, 1, 7, 0, 9, 4'b0000, 4'b0000);
    chk("R4 first access", sd_of(0), 16);
    event_go(0, 1, 7, 0, 9, 4'b0000, 4'b0000);
    chk("R4 alone hit", sd_of(0), 32);
    event_go(0, 1, 8, 0, 9, 4'b0000, 4'b0000);
    chk("R4 alone miss", sd_of(0), 32);
    event_go(0, 1, 8, 0, 3, 4'b0000, 4'b0000);
    chk("R4 row updated", sd_of(0), 48);
    event_go(0, 2, 8, 0, 3, 4'b0000, 4'b0000);
    chk("R4 other bank", sd_of(0), 48);
    chk("R9 idle thread", sd_of(1), 16);

    // R7 threshold strictness, R8 latency
    chk("R7 flag 3.0 vs 2.0", int'(unf), 1);
    @(negedge clk); thresh = 8'd48;
    #1 chk("R8 flag before edge", int'(unf), 1);
    @(posedge clk); #1 chk("R7 R8 flag equal ratio", int'(unf), 0);
    @(negedge clk); thresh = 8'd47;
    @(posedge clk); #1 chk("R7 flag just above", int'(unf), 1);
    chk("R6 worst own", int'(worst), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule